// File: doc/BRIEF.md
# Event interrupt, halt and reset sequencer

This block sits beside a pair of serial-bus command engines. Each engine has two command queues. The block collects the engines' single-cycle event pulses into one sticky 32-bit status word. It drives one level interrupt line, which is high whenever a status bit is set and its bit in the enable register is also set.

Software clears status bits in two steps. It first stages the bits to clear by writing ones. It then writes a commit strobe, and only the commit removes the staged bits from the status word.

The block also takes halt and reset requests and holds them towards the queue engines. A halt request names one engine. A reset request is a command word. The block acknowledges each request with a status bit. The acknowledge comes once every queue the request targets has reported idle for a parameterised run of consecutive cycles.

Top module: `evt_irq_unit`

## Requirements
- R1: Event pulses set status bits, and the bits stay set until cleared:
  - read-done of engine m sets bit 12m;
  - report of queue q of engine m sets bit 4+4q+12m;
  - NACK of queue q of engine m sets bit 27+2m+q;
  - the eight general error inputs of engine m (`q_err_i[8m+k]`, k = 0..7) set bits 1, 2, 5, 6, 7, 9, 10, 11 in that order, plus 12m.
- R2: `irq_o` is high exactly when status AND enable is nonzero. It follows register changes in the same cycle.
- R3: A write to address 2 ORs the write data into a staging word and leaves the status word unchanged. A write to address 3 with data bit 0 set clears the staged bits from the status word and empties the staging word. A write to address 3 with data bit 0 clear has no effect.
- R4: An event that arrives on the same clock edge as a commit keeps its status bit set, even if that bit was staged for clearing.
- R5: A write to address 4 with data bit m set raises `halt_o[m]` from the next cycle. When both queues of engine m have been idle on ACK_DLY consecutive clock edges, status bit 25+m is set and `halt_o[m]` falls on that same edge.
- R6: A halt or reset acknowledge is never raised on an edge where a targeted queue is not idle. Any non-idle cycle restarts the idle count.
- R7: A write to address 5 whose data ANDed with 0x0F73F3F7 is nonzero drives that masked value on `rst_o`. The request targets:
  - both queues of engine 0 if any of data bits 4..9 is set;
  - both queues of engine 1 if any of data bits 12..17 is set.

  After ACK_DLY consecutive idle edges of the targeted queues, status bit 24 is set and `rst_o` returns to 0.
- R8: A halt request for an engine whose halt is still pending has no effect. A reset command written while a reset is pending has no effect. A reset command whose masked value is zero has no effect.
- R9: After reset, the status, enable and staging words are zero, and `irq_o`, `halt_o` and `rst_o` are low.
- R10: `reg_rdata_o` is combinational:
  - address 0 returns the status word;
  - address 1 returns the enable word, which address 1 writes;
  - address 2 returns the staging word;
  - every other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| rd_done_i | input | 2 | Read-done pulse per engine |
| q_report_i | input | 4 | Report pulse per queue, index 2m+q |
| q_nack_i | input | 4 | NACK pulse per queue, index 2m+q |
| q_err_i | input | 16 | General error pulses, eight per engine |
| q_idle_i | input | 4 | Queue idle flags, index 2m+q |
| halt_o | output | 2 | Halt request held per engine |
| rst_o | output | 32 | Masked reset command held until done |
| irq_o | output | 1 | Interrupt line |

## Verification
The hardest cases to reach from the ports are the narrow races:
- an event landing on the very edge of a commit that clears its own bit;
- a second halt or reset request landing while the first still waits for idle queues.

The bench reaches them with directed sequences that line up the event pulse or the repeated write on a counted cycle. It also holds chosen idle flags low for several cycles, so that an acknowledge has to wait and its idle count has to restart. A stretch of random events, idle toggles and register writes then runs against the cycle-accurate model to cover the interleavings.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int DW         = 32;
  localparam int AW         = 3;
  localparam int NMST       = 2;
  localparam int QPM        = 2;
  localparam int NQ         = NMST * QPM;
  localparam int GERR_PM    = 8;
  localparam int MST_STRIDE = 12;
  localparam int RPT_BASE   = 4;
  localparam int RPT_STEP   = 4;
  localparam int BIT_RST_DN = 24;
  localparam int BIT_HLT_AK = 25;
  localparam int BIT_NACK   = 27;

  typedef enum logic [AW-1:0] {
    A_STS    = 3'd0,
    A_MSK    = 3'd1,
    A_CLR    = 3'd2,
    A_COMMIT = 3'd3,
    A_HALT   = 3'd4,
    A_RST    = 3'd5
  } reg_addr_e;

  localparam logic [DW-1:0] RST_ALL    = 32'h0F73_F3F7;
  localparam logic [DW-1:0] RST_M0_GRP = 32'h0000_03F0;
  localparam logic [DW-1:0] RST_M1_GRP = 32'h0003_F000;

  function automatic logic [DW-1:0] rst_grp(input int m);
    return (m == 0) ? RST_M0_GRP : RST_M1_GRP;
  endfunction

  // general error pins land on bits 1,2,5,6,7,9,10,11 of the engine's slice
  function automatic logic [DW-1:0] gerr_place(input logic [GERR_PM-1:0] e, input int m);
    logic [11:0] f;
    f = {e[7:5], 1'b0, e[4:2], 2'b00, e[1:0], 1'b0};
    return DW'(f) << (m * MST_STRIDE);
  endfunction

  function automatic logic [DW-1:0] place_events(
    input logic [NMST-1:0]         rd,
    input logic [NQ-1:0]           rpt,
    input logic [NQ-1:0]           nack,
    input logic [NMST*GERR_PM-1:0] gerr
  );
    logic [DW-1:0] v;
    v = '0;
    for (int m = 0; m < NMST; m++) begin
      v[m*MST_STRIDE] = rd[m];
      for (int q = 0; q < QPM; q++) begin
        v[m*MST_STRIDE + RPT_BASE + q*RPT_STEP] = rpt[m*QPM+q];
        v[BIT_NACK + m*QPM + q]                  = nack[m*QPM+q];
      end
      v = v | gerr_place(gerr[m*GERR_PM +: GERR_PM], m);
    end
    return v;
  endfunction
endpackage

// File: rtl/evt_sts_reg.sv
module evt_sts_reg
  import evt_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] set_i,
  input  logic          stage_we_i,
  input  logic          commit_i,
  input  logic          mask_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] sts_o,
  output logic [DW-1:0] msk_o,
  output logic [DW-1:0] pend_o,
  output logic          irq_o
);
  logic [DW-1:0] sts_q, msk_q, pend_q;
  logic [DW-1:0] clr_now;

  assign clr_now = commit_i ? pend_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q  <= '0;
      msk_q  <= '0;
      pend_q <= '0;
    end else begin
      // new events win over a clear on the same edge
      sts_q <= (sts_q & ~clr_now) | set_i;
      if (commit_i)        pend_q <= '0;
      else if (stage_we_i) pend_q <= pend_q | wdata_i;
      if (mask_we_i)       msk_q  <= wdata_i;
    end
  end

  assign sts_o  = sts_q;
  assign msk_o  = msk_q;
  assign pend_o = pend_q;
  assign irq_o  = |(sts_q & msk_q);
endmodule

// File: rtl/evt_ack_timer.sv
module evt_ack_timer #(
  parameter int ACK_DLY = 4,
  parameter int NQ      = 4,
  parameter int W       = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [W-1:0]  req_data_i,
  input  logic [NQ-1:0] req_sel_i,
  input  logic [NQ-1:0] q_idle_i,
  output logic          busy_o,
  output logic [W-1:0]  hold_o,
  output logic          ack_o
);
  localparam int CW = (ACK_DLY < 2) ? 1 : $clog2(ACK_DLY);
  localparam logic [CW-1:0] LAST = CW'(ACK_DLY - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [NQ-1:0] sel_q;
  logic [W-1:0]  hold_q;
  logic          all_idle, fin;

  assign all_idle = &(q_idle_i | ~sel_q);
  assign fin      = busy_q & all_idle & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sel_q  <= '0;
      hold_q <= '0;
    end else if (!busy_q) begin
      if (req_i) begin
        busy_q <= 1'b1;
        hold_q <= req_data_i;
        sel_q  <= req_sel_i;
        cnt_q  <= '0;
      end
    end else if (!all_idle) begin
      cnt_q <= '0;
    end else if (fin) begin
      busy_q <= 1'b0;
      hold_q <= '0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign hold_o = hold_q;
  assign ack_o  = fin;
endmodule

// File: rtl/evt_reg_if.sv
module evt_reg_if
  import evt_irq_pkg::*;
(
  input  logic            reg_wr_i,
  input  logic [AW-1:0]   reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  input  logic [DW-1:0]   sts_i,
  input  logic [DW-1:0]   msk_i,
  input  logic [DW-1:0]   pend_i,
  output logic            stage_we_o,
  output logic            commit_o,
  output logic            mask_we_o,
  output logic [NMST-1:0] halt_req_o,
  output logic            rst_req_o,
  output logic [DW-1:0]   rst_val_o,
  output logic [NQ-1:0]   rst_sel_o,
  output logic [DW-1:0]   rdata_o
);
  assign stage_we_o = reg_wr_i && (reg_addr_i == A_CLR);
  assign commit_o   = reg_wr_i && (reg_addr_i == A_COMMIT) && reg_wdata_i[0];
  assign mask_we_o  = reg_wr_i && (reg_addr_i == A_MSK);
  assign rst_val_o  = reg_wdata_i & RST_ALL;
  assign rst_req_o  = reg_wr_i && (reg_addr_i == A_RST) && (|rst_val_o);

  for (genvar m = 0; m < NMST; m++) begin : g_mst
    assign halt_req_o[m] = reg_wr_i && (reg_addr_i == A_HALT) && reg_wdata_i[m];
    assign rst_sel_o[m*QPM +: QPM] = {QPM{|(reg_wdata_i & rst_grp(m))}};
  end

  always_comb begin
    case (reg_addr_i)
      A_STS:   rdata_o = sts_i;
      A_MSK:   rdata_o = msk_i;
      A_CLR:   rdata_o = pend_i;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
  import evt_irq_pkg::*;
#(
  parameter int ACK_DLY = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    reg_wr_i,
  input  logic [AW-1:0]           reg_addr_i,
  input  logic [DW-1:0]           reg_wdata_i,
  output logic [DW-1:0]           reg_rdata_o,
  input  logic [NMST-1:0]         rd_done_i,
  input  logic [NQ-1:0]           q_report_i,
  input  logic [NQ-1:0]           q_nack_i,
  input  logic [NMST*GERR_PM-1:0] q_err_i,
  input  logic [NQ-1:0]           q_idle_i,
  output logic [NMST-1:0]         halt_o,
  output logic [DW-1:0]           rst_o,
  output logic                    irq_o
);
  logic [DW-1:0]   sts_q, msk_q, pend_q, set_vec;
  logic            stage_we, commit, mask_we, rst_req, rst_ack;
  logic [NMST-1:0] halt_req, halt_ack;
  logic [DW-1:0]   rst_val;
  logic [NQ-1:0]   rst_sel;

  evt_reg_if u_regs (
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .sts_i       (sts_q),
    .msk_i       (msk_q),
    .pend_i      (pend_q),
    .stage_we_o  (stage_we),
    .commit_o    (commit),
    .mask_we_o   (mask_we),
    .halt_req_o  (halt_req),
    .rst_req_o   (rst_req),
    .rst_val_o   (rst_val),
    .rst_sel_o   (rst_sel),
    .rdata_o     (reg_rdata_o)
  );

  for (genvar m = 0; m < NMST; m++) begin : g_halt
    logic [0:0] hold_unused;
    evt_ack_timer #(.ACK_DLY(ACK_DLY), .NQ(NQ), .W(1)) u_halt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (halt_req[m]),
      .req_data_i (1'b1),
      .req_sel_i  (NQ'({QPM{1'b1}}) << (m*QPM)),
      .q_idle_i   (q_idle_i),
      .busy_o     (halt_o[m]),
      .hold_o     (hold_unused),
      .ack_o      (halt_ack[m])
    );
  end

  logic rst_busy;
  evt_ack_timer #(.ACK_DLY(ACK_DLY), .NQ(NQ), .W(DW)) u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (rst_req),
    .req_data_i (rst_val),
    .req_sel_i  (rst_sel),
    .q_idle_i   (q_idle_i),
    .busy_o     (rst_busy),
    .hold_o     (rst_o),
    .ack_o      (rst_ack)
  );

  always_comb begin
    set_vec = place_events(rd_done_i, q_report_i, q_nack_i, q_err_i);
    set_vec[BIT_RST_DN] = rst_ack;
    for (int m = 0; m < NMST; m++) set_vec[BIT_HLT_AK + m] = halt_ack[m];
  end

  evt_sts_reg u_sts (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_vec),
    .stage_we_i (stage_we),
    .commit_i   (commit),
    .mask_we_i  (mask_we),
    .wdata_i    (reg_wdata_i),
    .sts_o      (sts_q),
    .msk_o      (msk_q),
    .pend_o     (pend_q),
    .irq_o      (irq_o)
  );

  logic unused_busy;
  assign unused_busy = rst_busy;
endmodule

// File: rtl/evt_irq_unit_chk.sv
module evt_irq_unit_chk
  import evt_irq_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            irq_o,
  input logic [NMST-1:0] halt_o,
  input logic [DW-1:0]   rst_o,
  input logic            reg_wr_i,
  input logic [AW-1:0]   reg_addr_i,
  input logic [DW-1:0]   reg_wdata_i,
  input logic [NQ-1:0]   q_idle_i,
  input logic [DW-1:0]   sts_q,
  input logic [DW-1:0]   msk_q
);
  logic commit_w;
  assign commit_w = reg_wr_i && (reg_addr_i == A_COMMIT) && reg_wdata_i[0];

  AST_STS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_w |=> ((sts_q & $past(sts_q)) == $past(sts_q))); // R1

  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msk_q == '0) |-> !irq_o); // R2

  AST_HALT0_ACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(halt_o[0]) |-> sts_q[BIT_HLT_AK]); // R5

  AST_HALT1_ACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(halt_o[1]) |-> sts_q[BIT_HLT_AK+1]); // R5

  AST_HALT_BUSY_Q: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o[0] && !(q_idle_i[0] && q_idle_i[1])) |=> halt_o[0]); // R6

  AST_RST_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(|rst_o) |-> sts_q[BIT_RST_DN]); // R7

  AST_RST_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rst_o) |=> ((rst_o == $past(rst_o)) || (rst_o == '0))); // R8
endmodule

bind evt_irq_unit evt_irq_unit_chk i_chk (.*);

// File: tb/test_evt_irq_unit.sv
module test_evt_irq_unit;
  localparam int ACK_DLY = 4;
  localparam logic [31:0] FULL = 32'h0F73F3F7;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [1:0]  rd_done = '0;
  logic [3:0]  rpt = '0, nack = '0, idle = 4'hF;
  logic [15:0] gerr = '0;
  logic [1:0]  halt;
  logic [31:0] rsto;
  logic        irq;

  always #2.5 clk = ~clk;

  evt_irq_unit #(.ACK_DLY(ACK_DLY)) i_evt_irq_unit (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rd_done_i(rd_done),
    .q_report_i(rpt), .q_nack_i(nack), .q_err_i(gerr), .q_idle_i(idle),
    .halt_o(halt), .rst_o(rsto), .irq_o(irq)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // reference model state
  logic [31:0] m_sts = '0, m_msk = '0, m_pend = '0, m_rhold = '0;
  logic [1:0]  m_hb = '0;
  int          m_hc[2] = '{0, 0};
  logic        m_rb = 1'b0;
  int          m_rc = 0;
  logic [3:0]  m_rsel = '0;
  int          gpos[8] = '{1, 2, 5, 6, 7, 9, 10, 11};

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] evt_set();
    logic [31:0] s = '0;
    for (int m = 0; m < 2; m++) begin
      if (rd_done[m]) s[12*m] = 1'b1;
      for (int q = 0; q < 2; q++) begin
        if (rpt[2*m+q])  s[12*m + 4 + 4*q] = 1'b1;
        if (nack[2*m+q]) s[27 + 2*m + q]   = 1'b1;
      end
      for (int k = 0; k < 8; k++) if (gerr[8*m+k]) s[gpos[k] + 12*m] = 1'b1;
    end
    return s;
  endfunction

  function automatic logic [31:0] m_rdata();
    case (addr)
      3'd0: return m_sts;
      3'd1: return m_msk;
      3'd2: return m_pend;
      default: return '0;
    endcase
  endfunction

  task automatic model_tick();
    logic [31:0] setv, clr;
    logic [1:0]  hb_old;
    logic        rb_old, commit;
    setv   = evt_set();
    hb_old = m_hb;
    rb_old = m_rb;
    for (int m = 0; m < 2; m++) begin
      if (hb_old[m]) begin
        if (idle[2*m] && idle[2*m+1]) begin
          if (m_hc[m] == ACK_DLY-1) begin
            setv[25+m] = 1'b1; m_hb[m] = 1'b0; m_hc[m] = 0;
          end else m_hc[m]++;
        end else m_hc[m] = 0;
      end
    end
    if (rb_old) begin
      if ((idle | ~m_rsel) == 4'hF) begin
        if (m_rc == ACK_DLY-1) begin
          setv[24] = 1'b1; m_rb = 1'b0; m_rhold = '0; m_rc = 0;
        end else m_rc++;
      end else m_rc = 0;
    end
    commit = wr && addr == 3'd3 && wdata[0];
    clr    = commit ? m_pend : '0;
    m_sts  = (m_sts & ~clr) | setv;
    if (commit) m_pend = '0;
    else if (wr && addr == 3'd2) m_pend = m_pend | wdata;
    if (wr && addr == 3'd1) m_msk = wdata;
    if (wr && addr == 3'd4)
      for (int m = 0; m < 2; m++)
        if (!hb_old[m] && wdata[m]) begin m_hb[m] = 1'b1; m_hc[m] = 0; end
    if (wr && addr == 3'd5 && !rb_old && (wdata & FULL) != 0) begin
      m_rb = 1'b1; m_rc = 0; m_rhold = wdata & FULL;
      m_rsel = {{2{|(wdata & 32'h0003F000)}}, {2{|(wdata & 32'h000003F0)}}};
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_tick();
    @(negedge clk);
    chk("R10 rdata", rdata, m_rdata());
    chk("R2 irq", {31'd0, irq}, {31'd0, |(m_sts & m_msk)});
    chk("R5 halt", {30'd0, halt}, {30'd0, m_hb});
    chk("R7 rst", rsto, m_rhold);
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    step();
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    step();
    d = rdata;
  endtask

  task automatic clear_all();
    wreg(3'd2, 32'hFFFF_FFFF);
    wreg(3'd3, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 status", rdata, 32'h0);
    chk("R9 irq", {31'd0, irq}, 32'h0);
    chk("R9 halt", {30'd0, halt}, 32'h0);
    chk("R9 rst", rsto, 32'h0);
    rst_n = 1'b1;
    step();

    // R1 event placement
    rd_done = 2'b01; step(); rd_done = '0;
    rpt = 4'b1000; step(); rpt = '0;
    nack = 4'b0010; step(); nack = '0;
    gerr = 16'h0100; step(); gerr = '0;
    gerr = 16'h0080; step(); gerr = '0;
    rreg(3'd0, v);
    chk("R1 event bits", v, 32'h10102801);
    clear_all();
    rreg(3'd0, v);
    chk("R3 clear all", v, 32'h0);

    // R3 staged clear
    rd_done = 2'b10; step(); rd_done = '0;
    wreg(3'd2, 32'h1000);
    rreg(3'd0, v); chk("R3 staged only", v, 32'h1000);
    rreg(3'd2, v); chk("R10 staging read", v, 32'h1000);
    wreg(3'd3, 32'h0);
    rreg(3'd0, v); chk("R3 commit bit0 low", v, 32'h1000);
    wreg(3'd3, 32'h1);
    rreg(3'd0, v); chk("R3 commit", v, 32'h0);

    // R4 event beats clear
    rpt = 4'b0001; step(); rpt = '0;
    wreg(3'd2, 32'h10);
    rpt = 4'b0001; wreg(3'd3, 32'h1); rpt = '0;
    rreg(3'd0, v); chk("R4 event wins", v, 32'h10);
    clear_all();

    // R2 interrupt masking
    nack = 4'b0100; step(); nack = '0;
    wreg(3'd1, 32'h2000_0000);
    chk("R2 irq enabled", {31'd0, irq}, 32'h1);
    rreg(3'd1, v); chk("R10 mask read", v, 32'h2000_0000);
    wreg(3'd1, 32'h0);
    chk("R2 irq masked", {31'd0, irq}, 32'h0);
    clear_all();

    // R5 halt with idle queues
    wreg(3'd4, 32'h1);
    chk("R5 halt raised", {30'd0, halt}, 32'h1);
    step(); step(); step();
    chk("R5 halt still held", {30'd0, halt}, 32'h1);
    step();
    chk("R5 halt dropped", {30'd0, halt}, 32'h0);
    rreg(3'd0, v); chk("R5 ack bit", v, 32'h0200_0000);
    clear_all();

    // R6 halt waits for busy queue
    idle = 4'b1011;
    wreg(3'd4, 32'h2);
    repeat (10) step();
    rreg(3'd0, v); chk("R6 no ack while busy", v, 32'h0);
    chk("R6 halt held", {30'd0, halt}, 32'h2);
    idle = 4'hF; step(); step();
    idle = 4'b0111; step();
    idle = 4'hF; step(); step(); step();
    chk("R6 count restarted", {30'd0, halt}, 32'h2);
    step();
    rreg(3'd0, v); chk("R6 ack after idle", v, 32'h0400_0000);
    clear_all();

    // R8 repeated halt ignored
    wreg(3'd4, 32'h1);
    step(); step();
    wreg(3'd4, 32'h1);
    step();
    chk("R8 halt not extended", {30'd0, halt}, 32'h0);
    clear_all();

    // R8 zero reset command
    wreg(3'd5, 32'hF000_0008);
    chk("R8 zero cmd", rsto, 32'h0);

    // R7 full reset
    idle = 4'b1110;
    wreg(3'd5, 32'hFFFF_FFFF);
    chk("R7 rst driven", rsto, FULL);
    wreg(3'd5, 32'h0000_03F1);
    chk("R8 rst not replaced", rsto, FULL);
    repeat (6) step();
    rreg(3'd0, v); chk("R7 waits idle", v, 32'h0);
    idle = 4'hF;
    repeat (ACK_DLY) step();
    chk("R7 rst released", rsto, 32'h0);
    rreg(3'd0, v); chk("R7 done bit", v, 32'h0100_0000);
    clear_all();

    // R7 engine 1 reset ignores engine 0 queues
    idle = 4'b1100;
    wreg(3'd5, 32'h0003_F001);
    repeat (ACK_DLY) step();
    chk("R7 per-engine done", rsto, 32'h0);
    idle = 4'hF;
    clear_all();

    // random mix against the model
    for (int i = 0; i < 400; i++) begin
      int r;
      r       = $urandom_range(0, 99);
      rd_done = 2'($urandom_range(0, 3) & {2{r < 20}});
      rpt     = 4'($urandom_range(0, 15) & {4{r < 25}});
      nack    = 4'($urandom_range(0, 15) & {4{r < 10}});
      gerr    = 16'($urandom & {16{r < 15}});
      idle    = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'hF;
      addr    = 3'($urandom_range(0, 7));
      wr      = (r >= 70);
      wdata   = (addr == 3'd3) ? 32'($urandom_range(0, 1)) : $urandom;
      step();
    end
    wr = 1'b0; rd_done = '0; rpt = '0; nack = '0; gerr = '0; idle = 4'hF;
    step();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule